// File: doc/BRIEF.md
# Write-Masked Indirect Configuration Bridge

This block is a small register bank on a single-cycle register bus. Each 32-bit write carries its own bit enables: the upper half-word says which bits of the lower half-word may change. All other stored bits keep their value. This lets software change one field, or one bit, without reading the register first.

The bank has three registers. A lane-idle word drives one idle output for each of four lanes. An indirect control word holds a 6-bit configuration address, 4 bits of write data and a software strobe. A read-only status word returns the configuration entry that the current address selects. Behind the indirect port sits a 64-entry store of 4-bit configuration values, which stands in for the PHY settings.

A small state machine watches the stored strobe bit. It has two states:
- `STRB_LOW`: the strobe was last seen at 0.
- `STRB_HIGH`: the strobe was last seen at 1.

Its transitions are:
- `LOW->HIGH` (commit): taken when the strobe reads 1 in `STRB_LOW`. On this transition the store writes the addressed entry.
- `HIGH->LOW` (rearm): taken when the strobe reads 0 in `STRB_HIGH`.
- `LOW->LOW` and `HIGH->HIGH` (hold): taken in every other case.

Software commits an entry in three steps. It sets the address and data. It raises the strobe with a masked write. It then lowers the strobe with a second masked write.

Top module: `masked_cfg_bridge`

## Requirements
- R1: On a write to a control register, stored bit n (0..15) takes bit n of the write data only if bit n+16 is 1. Every other stored bit keeps its value.
- R2: Reading the lane-idle register (offset 0x00) or the indirect control register (offset 0x04) returns its 16 stored bits in bits 15:0, with bits 31:16 reading as zero.
- R3: After reset, the indirect control word is 0x0000. The lane-idle word is 0x0078, so all four lanes are idle. Every configuration entry is 0.
- R4: The indirect control word places the strobe in bit 0, the configuration address in bits 6:1 and the write data in bits 10:7. When the stored strobe goes from 0 to 1, the data is committed to the addressed entry. The entry is readable in the cycle after the write that raised the strobe.
- R5: While the strobe stays at 1, changes to address or data commit nothing. A new commit needs the strobe to return to 0 and rise again.
- R6: The status register at offset 0x08 returns, in bits 11:8, the entry selected by the current address. All its other bits read as zero. Writes to it have no effect.
- R7: Lane-idle output i (0..3) follows bit 3+i of the lane-idle word, and 1 means idle.
- R8: Writes to offsets other than 0x00, 0x04 and 0x08 change nothing, and reads from them return zero.
- R9: One write with mask 0x07FF updates the address and the data together and leaves bits 15:11 of the control word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Write enable for one cycle |
| bus_addr | input | 8 | Byte offset for both read and write |
| bus_wdata | input | 32 | Write data: bits 31:16 are the bit mask, bits 15:0 are the value |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| lane_idle | output | 4 | Idle control for each lane, 1 = idle |

## Verification
The bench looks for the following faults:
- A mask taken from the wrong half-word, or ignored, would overwrite bits that the mask leaves at 0. The bench makes all-zero, partial and full-mask writes and reads each result back.
- A commit on the strobe level instead of its rising edge would overwrite an entry when the address or data changes while the strobe is held high. The bench changes both with the strobe high and checks that nothing was committed.
- A store that never commits, or commits a cycle late, would return stale status data in the cycle after the strobe rises.
- A broken decode would let writes to the status register or to an unmapped offset alter state, or would make unmapped reads return nonzero data.
- A wrong reset value would leave the lanes out of idle after reset.

// File: rtl/masked_cfg_pkg.sv
package masked_cfg_pkg;
    localparam int BUS_W  = 32;
    localparam int HALF_W = BUS_W / 2;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_IDLE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTL  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h08;

    // Field positions inside the indirect control word
    localparam int STRB_POS  = 0;
    localparam int CADDR_LSB = 1;
    localparam int CDATA_LSB = 7;
    // Position of the returned entry inside the status word
    localparam int STAT_LSB  = 8;
    // First lane-idle bit inside the lane-idle word
    localparam int IDLE_LSB  = 3;

    typedef enum logic [0:0] {
        STRB_LOW  = 1'b0,
        STRB_HIGH = 1'b1
    } strb_state_e;
endpackage

// File: rtl/mask_reg16.sv
module mask_reg16 #(
    parameter int          W        = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [2*W-1:0] wword,
    output logic [W-1:0]   q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[b] <= RST_VAL[b];
            end else if (we && wword[W+b]) begin
                q[b] <= wword[b];
            end
        end
    end
endmodule

// File: rtl/cfg_entry_store.sv
module cfg_entry_store #(
    parameter int AW = 6,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[e] <= '0;
            end else if (we && (waddr == AW'(e))) begin
                mem[e] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/strobe_edge_fsm.sv
module strobe_edge_fsm
    import masked_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic commit
);
    strb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STRB_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            STRB_LOW: begin
                if (strobe) begin
                    state_d = STRB_HIGH;
                    commit  = 1'b1;
                end
            end
            STRB_HIGH: begin
                if (!strobe) begin
                    state_d = STRB_LOW;
                end
            end
            default: state_d = STRB_LOW;
        endcase
    end
endmodule

// File: rtl/masked_cfg_bridge.sv
module masked_cfg_bridge
    import masked_cfg_pkg::*;
#(
    parameter int CFG_AW = 6,
    parameter int CFG_DW = 4,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [LANES-1:0]  lane_idle
);
    localparam logic [HALF_W-1:0] IDLE_RST = HALF_W'(((1 << LANES) - 1) << IDLE_LSB);

    logic [HALF_W-1:0] idle_q;
    logic [HALF_W-1:0] ctl_q;
    logic [CFG_DW-1:0] entry_rd;
    logic              commit;
    logic              we_idle;
    logic              we_ctl;

    assign we_idle = bus_wen && (bus_addr == OFS_IDLE);
    assign we_ctl  = bus_wen && (bus_addr == OFS_CTL);

    mask_reg16 #(.W(HALF_W), .RST_VAL(IDLE_RST)) u_idle_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_idle),
        .wword (bus_wdata),
        .q     (idle_q)
    );

    mask_reg16 #(.W(HALF_W), .RST_VAL('0)) u_ctl_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_ctl),
        .wword (bus_wdata),
        .q     (ctl_q)
    );

    strobe_edge_fsm u_strobe_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (ctl_q[STRB_POS]),
        .commit (commit)
    );

    cfg_entry_store #(.AW(CFG_AW), .DW(CFG_DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .waddr (ctl_q[CADDR_LSB +: CFG_AW]),
        .wdata (ctl_q[CDATA_LSB +: CFG_DW]),
        .raddr (ctl_q[CADDR_LSB +: CFG_AW]),
        .rdata (entry_rd)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_idle[l] = idle_q[IDLE_LSB + l];
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_IDLE: bus_rdata[HALF_W-1:0] = idle_q;
            OFS_CTL:  bus_rdata[HALF_W-1:0] = ctl_q;
            OFS_STAT: bus_rdata[STAT_LSB +: CFG_DW] = entry_rd;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/masked_cfg_bridge_chk.sv
module masked_cfg_bridge_chk
    import masked_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wen,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [3:0]        lane_idle,
    input logic [HALF_W-1:0] idle_q,
    input logic [HALF_W-1:0] ctl_q
);
    logic mapped;
    assign mapped = (bus_addr == OFS_IDLE) || (bus_addr == OFS_CTL) || (bus_addr == OFS_STAT);

    assert_mask_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == OFS_CTL && bus_wdata[31:16] == '0) |=> $stable(ctl_q));

    assert_mask_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == OFS_IDLE) |=>
        ((idle_q & $past(bus_wdata[31:16])) == ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))));

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == '0);

    assert_stat_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_STAT) |-> (bus_rdata[7:0] == '0 && bus_rdata[15:12] == '0));

    assert_lane_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wen |=> $stable(lane_idle));

    assert_unmapped_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && !mapped) |=> ($stable(idle_q) && $stable(ctl_q)));

    assert_unmapped_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> bus_rdata == '0);
endmodule

bind masked_cfg_bridge masked_cfg_bridge_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .lane_idle (lane_idle),
    .idle_q    (idle_q),
    .ctl_q     (ctl_q)
);

// File: tb/masked_cfg_bridge_bench.sv
module masked_cfg_bridge_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {write addr[8], write word[32], read addr[8], expected[32], requirement[8]}
    localparam logic [87:0] VEC [NVEC] = '{
        {8'h00, 32'hFFFF_A5A5, 8'h00, 32'h0000_A5A5, 8'd2},  // R2 full mask
        {8'h00, 32'h00F0_0000, 8'h00, 32'h0000_A505, 8'd1},  // R1 partial clear
        {8'h00, 32'h0000_FFFF, 8'h00, 32'h0000_A505, 8'd1},  // R1 zero mask
        {8'h04, 32'h07FF_060A, 8'h04, 32'h0000_060A, 8'd9},  // R9 addr+data
        {8'h04, 32'hF800_F800, 8'h04, 32'h0000_FE0A, 8'd1},  // R1 high bits
        {8'h04, 32'h07FF_0192, 8'h04, 32'h0000_F992, 8'd9},  // R9 keeps 15:11
        {8'h0C, 32'hFFFF_FFFF, 8'h0C, 32'h0000_0000, 8'd8},  // R8 unmapped
        {8'h08, 32'hFFFF_FFFF, 8'h00, 32'h0000_A505, 8'd6}   // R6 status write ignored
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  lane_idle;
    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    masked_cfg_bridge u_masked_cfg_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lane_idle (lane_idle)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wen = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic lane_check(input logic [3:0] exp, input string req);
        @(negedge clk);
        checks++;
        if (lane_idle !== exp) begin
            fails++;
            $display("FAIL %s lane_idle actual=%h expected=%h", req, lane_idle, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R3 reset state
        rd_check(8'h00, 32'h0000_0078, "R3");
        rd_check(8'h04, 32'h0000_0000, "R3");
        rd_check(8'h08, 32'h0000_0000, "R3");
        lane_check(4'hF, "R3");

        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][87:80], VEC[i][79:48]);
            tick();
            rd_check(VEC[i][47:40], VEC[i][39:8], $sformatf("R%0d", VEC[i][7:0]));
        end
        // R6 nothing committed so far: entry 9 reads 0
        rd_check(8'h08, 32'h0000_0000, "R6");

        // R4 commit data 0xC to entry 5
        wr(8'h04, 32'h07FF_060A);
        wr(8'h04, 32'h0001_0001);
        tick();
        rd_check(8'h08, 32'h0000_0C00, "R4");
        // R6 other entry untouched
        wr(8'h04, 32'h007E_0012);
        rd_check(8'h08, 32'h0000_0000, "R6");
        // R5 change addr/data with strobe still high
        wr(8'h04, 32'h07FE_0392);
        tick();
        rd_check(8'h08, 32'h0000_0000, "R5");
        wr(8'h04, 32'h0001_0000);
        tick();
        rd_check(8'h08, 32'h0000_0000, "R5");
        wr(8'h04, 32'h0001_0001);
        tick();
        rd_check(8'h08, 32'h0000_0700, "R4");
        wr(8'h04, 32'h007E_000A);
        rd_check(8'h08, 32'h0000_0C00, "R5");

        // R7 lane mapping
        wr(8'h00, 32'h0078_0028);
        lane_check(4'h5, "R7");
        wr(8'h00, 32'h0078_0050);
        lane_check(4'hA, "R7");

        // R3 reset clears store and lanes return to idle
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        lane_check(4'hF, "R3");
        wr(8'h04, 32'h007E_000A);
        rd_check(8'h08, 32'h0000_0000, "R3");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule